// File: doc/BRIEF.md
# Extension Opcode Hook for an Instruction Decoder

This block sits beside the decode stage of an existing in-order processor. It lets an attached extension unit add instructions without changing what the base machine does. Every instruction the decode stage hands over is classified by its 6-bit opcode into one of four groups:

- base instructions that write a destination register;
- base instructions that do not write one;
- opcodes nobody has defined, which retire as no-ops;
- a reserved block of eight opcodes that belongs to the extension.

The opcode and register specifiers of every accepted instruction are copied onto a tap bus, so the extension can observe the instruction stream. When a reserved opcode arrives and an extension is attached, the hook claims the instruction and takes it away from the base pipeline. It sends a request that carries a function index, the register specifiers and both register-file operand values. It then holds decode stalled until the extension answers. The answer is spliced into writeback in place of the base result, and an override flag marks that it came from the extension.

With no extension attached, reserved opcodes behave as plain no-ops: they write nothing and cost no stall. Writeback is registered, so each accepted instruction leaves exactly one writeback record. A base instruction's record appears on the cycle after it is accepted. An extension instruction's record appears on the cycle after its response handshake.

Top module: `xop_hook`

## Requirements
- R1: A base instruction with an opcode from 0x00 to 0x17, accepted when id_valid and id_ready are both high, produces a writeback record on the next cycle. The record has wb_valid=1, wb_we=1, wb_rd equal to its destination, wb_data equal to base_result and wb_override=0.
- R2: Opcodes 0x18 to 0x1F (base instructions with no destination) and opcodes 0x20 to 0x37 (unspecified) produce a writeback record with wb_valid=1, wb_we=0 and wb_override=0, and send no extension request.
- R3: With ext_present low, a reserved opcode (0x38 to 0x3F) retires as a no-op. Its record has wb_valid=1 and wb_we=0, id_ready stays high on the next cycle, and no request is raised.
- R4: For every accepted instruction, tap_valid is high in the accepting cycle, and tap_opcode, tap_rs1, tap_rs2 and tap_rd carry that instruction's fields.
- R5: With ext_present high, a reserved opcode raises x_req_valid on the next cycle. The request carries x_req_fidx equal to the opcode minus 0x38 (its low three bits), the three register specifiers, and the two operand values sampled when the instruction was accepted.
- R6: While x_req_valid is high and x_req_ready is low, the request stays valid and all of its fields stay unchanged.
- R7: From the cycle after an extension instruction is accepted until the cycle after its response handshake, id_ready is low. x_resp_ready is high only after the request handshake, so at most one extension instruction is outstanding and x_req_valid and x_resp_ready are never high together.
- R8: On the cycle after x_resp_valid and x_resp_ready are both high, the hook emits a record with wb_valid=1, wb_override=1 and wb_data equal to the response data. wb_rd is the destination of the claimed instruction.
- R9: A writeback record whose destination is register 0 has wb_we=0, whether the result came from the base datapath or from the extension.
- R10: After reset, id_ready=1, wb_valid=0, x_req_valid=0 and x_resp_ready=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_present | input | 1 | An extension unit is attached |
| id_valid | input | 1 | Decode stage presents an instruction |
| id_ready | output | 1 | Hook can accept an instruction (low while stalled) |
| id_opcode | input | 6 | Opcode of the presented instruction |
| id_rs1 | input | RAW | First source register specifier |
| id_rs2 | input | RAW | Second source register specifier |
| id_rd | input | RAW | Destination register specifier |
| rf_rs1_val | input | XLEN | Register-file value of the first source |
| rf_rs2_val | input | XLEN | Register-file value of the second source |
| base_result | input | XLEN | Result of the base datapath for the presented instruction |
| tap_valid | output | 1 | Tap bus carries an accepted instruction |
| tap_opcode | output | 6 | Tapped opcode |
| tap_rs1 | output | RAW | Tapped first source specifier |
| tap_rs2 | output | RAW | Tapped second source specifier |
| tap_rd | output | RAW | Tapped destination specifier |
| x_req_valid | output | 1 | Extension request valid |
| x_req_ready | input | 1 | Extension accepts the request |
| x_req_fidx | output | 3 | Function index inside the reserved block |
| x_req_rs1 | output | RAW | First source specifier of the claimed instruction |
| x_req_rs2 | output | RAW | Second source specifier of the claimed instruction |
| x_req_rd | output | RAW | Destination specifier of the claimed instruction |
| x_req_a | output | XLEN | First operand value |
| x_req_b | output | XLEN | Second operand value |
| x_resp_valid | input | 1 | Extension result valid |
| x_resp_ready | output | 1 | Hook is waiting for the result |
| x_resp_data | input | XLEN | Extension result |
| wb_valid | output | 1 | A writeback record is present |
| wb_we | output | 1 | The record writes the register file |
| wb_rd | output | RAW | Destination register of the record |
| wb_data | output | XLEN | Data to write |
| wb_override | output | 1 | The data comes from the extension |

## Verification
The bench builds the hook with XLEN=16 and RAW=3. The narrow register index makes destination register 0 easy to hit on both the base path and the extension path. Narrow data lets distinct operands and results be told apart at a glance. The extension model in the bench varies both the request-ready delay and the response latency, so exact stall lengths of several sizes are measured on id_ready. Toggling ext_present between runs of reserved opcodes covers both the no-op behaviour and the claimed behaviour of the same opcodes.

// File: rtl/xh_pkg.sv
package xh_pkg;
  localparam int OP_W      = 6;
  localparam int EXT_COUNT = 8;
  localparam int FIDX_W    = $clog2(EXT_COUNT);

  localparam logic [OP_W-1:0] WR_LAST   = 6'h17;
  localparam logic [OP_W-1:0] NOWR_LAST = 6'h1F;
  localparam logic [OP_W-1:0] EXT_BASE  = 6'h38;

  typedef enum logic [1:0] {
    CL_NOP  = 2'd0,
    CL_WR   = 2'd1,
    CL_NOWR = 2'd2,
    CL_EXT  = 2'd3
  } op_class_e;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_REQ  = 2'd1,
    XS_WAIT = 2'd2
  } xstate_e;

  function automatic logic in_reserved(input logic [OP_W-1:0] op);
    logic [OP_W:0] lo, hi, v;
    lo = {1'b0, EXT_BASE};
    hi = lo + (OP_W+1)'(EXT_COUNT);
    v  = {1'b0, op};
    return (v >= lo) && (v < hi);
  endfunction

  function automatic op_class_e classify(input logic [OP_W-1:0] op,
                                         input logic present);
    if (in_reserved(op))  return present ? CL_EXT : CL_NOP;
    if (op <= WR_LAST)    return CL_WR;
    if (op <= NOWR_LAST)  return CL_NOWR;
    return CL_NOP;
  endfunction

  function automatic logic [FIDX_W-1:0] fidx_of(input logic [OP_W-1:0] op);
    logic [OP_W-1:0] d;
    d = op - EXT_BASE;
    return d[FIDX_W-1:0];
  endfunction
endpackage

// File: rtl/xh_classify.sv
module xh_classify
  import xh_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic            ext_present,
  output logic            claim_ext,
  output logic            base_writes,
  output logic            reserved
);
  op_class_e cls;

  always_comb begin
    cls         = classify(opcode, ext_present);
    claim_ext   = (cls == CL_EXT);
    base_writes = (cls == CL_WR);
    reserved    = in_reserved(opcode);
  end
endmodule

// File: rtl/xh_ext_ctrl.sv
module xh_ext_ctrl
  import xh_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RAW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   opcode,
  input  logic [RAW-1:0]    rs1,
  input  logic [RAW-1:0]    rs2,
  input  logic [RAW-1:0]    rd,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [FIDX_W-1:0] req_fidx,
  output logic [RAW-1:0]    req_rs1,
  output logic [RAW-1:0]    req_rs2,
  output logic [RAW-1:0]    req_rd,
  output logic [XLEN-1:0]   req_a,
  output logic [XLEN-1:0]   req_b,
  input  logic              resp_valid,
  output logic              resp_ready,
  input  logic [XLEN-1:0]   resp_data,
  output logic              busy,
  output logic              done,
  output logic [RAW-1:0]    done_rd,
  output logic [XLEN-1:0]   done_data
);
  xstate_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      XS_IDLE: if (start)      state_d = XS_REQ;
      XS_REQ:  if (req_ready)  state_d = XS_WAIT;
      XS_WAIT: if (resp_valid) state_d = XS_IDLE;
      default:                 state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= XS_IDLE;
      req_fidx <= '0;
      req_rs1  <= '0;
      req_rs2  <= '0;
      req_rd   <= '0;
      req_a    <= '0;
      req_b    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == XS_IDLE && start) begin
        req_fidx <= fidx_of(opcode);
        req_rs1  <= rs1;
        req_rs2  <= rs2;
        req_rd   <= rd;
        req_a    <= a;
        req_b    <= b;
      end
    end
  end

  assign req_valid  = (state_q == XS_REQ);
  assign resp_ready = (state_q == XS_WAIT);
  assign busy       = (state_q != XS_IDLE);
  assign done       = resp_ready && resp_valid;
  assign done_rd    = req_rd;
  assign done_data  = resp_data;

  // R6: a pending request holds its valid and payload
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_fidx) && $stable(req_rd)
      && $stable(req_rs1) && $stable(req_rs2) && $stable(req_a) && $stable(req_b));

  // R7: request and response phases never overlap
  assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_valid, resp_ready}));
endmodule

// File: rtl/xh_wb_stage.sv
module xh_wb_stage #(
  parameter int XLEN = 32,
  parameter int RAW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            base_fire,
  input  logic            base_writes,
  input  logic [RAW-1:0]  base_rd,
  input  logic [XLEN-1:0] base_data,
  input  logic            ext_done,
  input  logic [RAW-1:0]  ext_rd,
  input  logic [XLEN-1:0] ext_data,
  output logic            wb_valid,
  output logic            wb_we,
  output logic [RAW-1:0]  wb_rd,
  output logic [XLEN-1:0] wb_data,
  output logic            wb_override
);
  logic            sel_we;
  logic [RAW-1:0]  sel_rd;
  logic [XLEN-1:0] sel_data;

  always_comb begin
    if (ext_done) begin
      sel_rd   = ext_rd;
      sel_data = ext_data;
      sel_we   = (ext_rd != '0);
    end else begin
      sel_rd   = base_rd;
      sel_data = base_data;
      sel_we   = base_writes && (base_rd != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid    <= 1'b0;
      wb_we       <= 1'b0;
      wb_rd       <= '0;
      wb_data     <= '0;
      wb_override <= 1'b0;
    end else begin
      wb_valid    <= ext_done || base_fire;
      wb_we       <= (ext_done || base_fire) && sel_we;
      wb_rd       <= sel_rd;
      wb_data     <= sel_data;
      wb_override <= ext_done;
    end
  end

  // R9: register 0 is never written
  assert_no_r0_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> wb_rd != '0);

  // R8: the override flag only appears on a valid record
  assert_override_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_override |-> wb_valid);
endmodule

// File: rtl/xop_hook.sv
module xop_hook
  import xh_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RAW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_present,
  input  logic              id_valid,
  output logic              id_ready,
  input  logic [OP_W-1:0]   id_opcode,
  input  logic [RAW-1:0]    id_rs1,
  input  logic [RAW-1:0]    id_rs2,
  input  logic [RAW-1:0]    id_rd,
  input  logic [XLEN-1:0]   rf_rs1_val,
  input  logic [XLEN-1:0]   rf_rs2_val,
  input  logic [XLEN-1:0]   base_result,
  output logic              tap_valid,
  output logic [OP_W-1:0]   tap_opcode,
  output logic [RAW-1:0]    tap_rs1,
  output logic [RAW-1:0]    tap_rs2,
  output logic [RAW-1:0]    tap_rd,
  output logic              x_req_valid,
  input  logic              x_req_ready,
  output logic [FIDX_W-1:0] x_req_fidx,
  output logic [RAW-1:0]    x_req_rs1,
  output logic [RAW-1:0]    x_req_rs2,
  output logic [RAW-1:0]    x_req_rd,
  output logic [XLEN-1:0]   x_req_a,
  output logic [XLEN-1:0]   x_req_b,
  input  logic              x_resp_valid,
  output logic              x_resp_ready,
  input  logic [XLEN-1:0]   x_resp_data,
  output logic              wb_valid,
  output logic              wb_we,
  output logic [RAW-1:0]    wb_rd,
  output logic [XLEN-1:0]   wb_data,
  output logic              wb_override
);
  logic            claim_ext, base_writes, reserved;
  logic            busy, fire, ext_start, base_fire, ext_done;
  logic [RAW-1:0]  done_rd;
  logic [XLEN-1:0] done_data;

  xh_classify u_cls (
    .opcode      (id_opcode),
    .ext_present (ext_present),
    .claim_ext   (claim_ext),
    .base_writes (base_writes),
    .reserved    (reserved)
  );

  assign id_ready  = !busy;
  assign fire      = id_valid && id_ready;
  assign ext_start = fire && claim_ext;
  assign base_fire = fire && !claim_ext;

  assign tap_valid  = fire;
  assign tap_opcode = id_opcode;
  assign tap_rs1    = id_rs1;
  assign tap_rs2    = id_rs2;
  assign tap_rd     = id_rd;

  xh_ext_ctrl #(.XLEN(XLEN), .RAW(RAW)) u_ext (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (ext_start),
    .opcode     (id_opcode),
    .rs1        (id_rs1),
    .rs2        (id_rs2),
    .rd         (id_rd),
    .a          (rf_rs1_val),
    .b          (rf_rs2_val),
    .req_valid  (x_req_valid),
    .req_ready  (x_req_ready),
    .req_fidx   (x_req_fidx),
    .req_rs1    (x_req_rs1),
    .req_rs2    (x_req_rs2),
    .req_rd     (x_req_rd),
    .req_a      (x_req_a),
    .req_b      (x_req_b),
    .resp_valid (x_resp_valid),
    .resp_ready (x_resp_ready),
    .resp_data  (x_resp_data),
    .busy       (busy),
    .done       (ext_done),
    .done_rd    (done_rd),
    .done_data  (done_data)
  );

  xh_wb_stage #(.XLEN(XLEN), .RAW(RAW)) u_wb (
    .clk         (clk),
    .rst_n       (rst_n),
    .base_fire   (base_fire),
    .base_writes (base_writes),
    .base_rd     (id_rd),
    .base_data   (base_result),
    .ext_done    (ext_done),
    .ext_rd      (done_rd),
    .ext_data    (done_data),
    .wb_valid    (wb_valid),
    .wb_we       (wb_we),
    .wb_rd       (wb_rd),
    .wb_data     (wb_data),
    .wb_override (wb_override)
  );

  // R3: reserved opcode without an extension: no stall, no request, no write
  assert_absent_noop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && reserved && !ext_present |=> id_ready && !x_req_valid && wb_valid && !wb_we);

  // R5: claimed opcode raises a request with its function index
  assert_req_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && reserved && ext_present |=>
      x_req_valid && x_req_fidx == $past(id_opcode[FIDX_W-1:0]) && x_req_a == $past(rf_rs1_val));

  // R7: decode stalls once an extension instruction is claimed
  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_start |=> !id_ready);

  // R8: response data lands in writeback as an override
  assert_override_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    x_resp_valid && x_resp_ready |=> wb_valid && wb_override && wb_data == $past(x_resp_data));

  // R1: a base write reaches writeback one cycle later with base data
  assert_base_wb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !reserved && id_opcode <= WR_LAST && id_rd != '0 |=>
      wb_valid && wb_we && !wb_override && wb_data == $past(base_result));
endmodule

// File: tb/test_xop_hook.sv
module test_xop_hook;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 16;
  localparam int RAW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_present = 1'b0;
  logic id_valid = 1'b0;
  logic id_ready;
  logic [5:0] id_opcode = '0;
  logic [RAW-1:0] id_rs1 = '0, id_rs2 = '0, id_rd = '0;
  logic [XLEN-1:0] rf_rs1_val = '0, rf_rs2_val = '0, base_result = '0;
  logic tap_valid;
  logic [5:0] tap_opcode;
  logic [RAW-1:0] tap_rs1, tap_rs2, tap_rd;
  logic x_req_valid;
  logic x_req_ready = 1'b0;
  logic [2:0] x_req_fidx;
  logic [RAW-1:0] x_req_rs1, x_req_rs2, x_req_rd;
  logic [XLEN-1:0] x_req_a, x_req_b;
  logic x_resp_valid = 1'b0;
  logic x_resp_ready;
  logic [XLEN-1:0] x_resp_data = '0;
  logic wb_valid, wb_we, wb_override;
  logic [RAW-1:0] wb_rd;
  logic [XLEN-1:0] wb_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  xop_hook #(.XLEN(XLEN), .RAW(RAW)) i_xop_hook (.*);

  int total = 0;
  int bad = 0;
  int last_waits = 0;
  int rdy_delay = 0;
  int resp_lat = 0;

  typedef struct packed {
    logic we; logic [RAW-1:0] rd; logic [XLEN-1:0] data; logic ovr;
  } wb_exp_t;
  typedef struct packed {
    logic [2:0] f; logic [RAW-1:0] rs1, rs2, rd; logic [XLEN-1:0] a, b;
  } req_exp_t;

  wb_exp_t  wbq[$];
  req_exp_t reqq[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] ext_fn(input logic [2:0] f,
                                             input logic [XLEN-1:0] a,
                                             input logic [XLEN-1:0] b);
    return (a ^ {b[XLEN-4:0], b[XLEN-1:XLEN-3]}) + XLEN'(f) * 16'd257;
  endfunction

  // driver: present one instruction, wait for acceptance, push expectations
  task automatic issue(input logic [5:0] op, input logic [RAW-1:0] s1,
                       input logic [RAW-1:0] s2, input logic [RAW-1:0] d,
                       input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                       input logic [XLEN-1:0] br);
    wb_exp_t e;
    req_exp_t r;
    int w = 0;
    bit rsv = (op >= 6'h38);
    @(negedge clk);
    id_valid = 1'b1; id_opcode = op; id_rs1 = s1; id_rs2 = s2; id_rd = d;
    rf_rs1_val = a; rf_rs2_val = b; base_result = br;
    #1;
    while (!id_ready) begin
      w++;
      @(negedge clk);
      #1;
    end
    last_waits = w;
    // R4: tap bus mirrors the accepted instruction
    check(tap_valid && tap_opcode == op && tap_rs1 == s1 && tap_rs2 == s2 && tap_rd == d,
          "R4", "tap fields", int'({tap_valid, tap_opcode, tap_rs1, tap_rs2, tap_rd}),
          int'({1'b1, op, s1, s2, d}));
    if (rsv && ext_present) begin
      r.f = op[2:0]; r.rs1 = s1; r.rs2 = s2; r.rd = d; r.a = a; r.b = b;
      reqq.push_back(r);
      e.we = (d != 0); e.rd = d; e.data = ext_fn(op[2:0], a, b); e.ovr = 1'b1;
    end else begin
      e.we = (op <= 6'h17) && (d != 0); e.rd = d; e.data = br; e.ovr = 1'b0;
    end
    wbq.push_back(e);
    @(posedge clk);
    #1;
    id_valid = 1'b0;
  endtask

  // monitor: compare every writeback record with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && wb_valid) begin
        if (wbq.size() == 0) begin
          check(0, "R2", "unexpected writeback", 1, 0);
        end else begin
          wb_exp_t e;
          e = wbq.pop_front();
          check(wb_we == e.we, e.ovr ? "R9/R8" : "R1/R2/R9", "wb_we", int'(wb_we), int'(e.we));
          check(wb_override == e.ovr, "R8", "wb_override", int'(wb_override), int'(e.ovr));
          if (e.we) begin
            check(wb_rd == e.rd, "R1", "wb_rd", int'(wb_rd), int'(e.rd));
            check(wb_data == e.data, e.ovr ? "R8" : "R1", "wb_data", int'(wb_data), int'(e.data));
          end
        end
      end
    end
  end

  // extension model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && x_req_valid) begin
        logic [2:0] f;
        logic [XLEN-1:0] a, b;
        check(!x_resp_ready, "R7", "resp_ready during request", int'(x_resp_ready), 0);
        if (reqq.size() == 0) begin
          check(0, "R3", "unexpected request", 1, 0);
        end else begin
          req_exp_t r;
          r = reqq.pop_front();
          check(x_req_fidx == r.f && x_req_rd == r.rd && x_req_rs1 == r.rs1 && x_req_rs2 == r.rs2,
                "R5", "request specifiers", int'({x_req_fidx, x_req_rs1, x_req_rs2, x_req_rd}),
                int'({r.f, r.rs1, r.rs2, r.rd}));
          check(x_req_a == r.a && x_req_b == r.b, "R5", "request operands",
                int'({x_req_a, x_req_b}), int'({r.a, r.b}));
        end
        f = x_req_fidx; a = x_req_a; b = x_req_b;
        repeat (rdy_delay) @(negedge clk);
        check(x_req_valid && x_req_fidx == f && x_req_a == a && x_req_b == b,
              "R6", "request held", int'({x_req_valid, x_req_a}), int'({1'b1, a}));
        x_req_ready = 1'b1;
        @(negedge clk);
        x_req_ready = 1'b0;
        repeat (resp_lat) @(negedge clk);
        check(x_resp_ready, "R7", "resp_ready while waiting", int'(x_resp_ready), 1);
        x_resp_valid = 1'b1;
        x_resp_data = ext_fn(f, a, b);
        @(negedge clk);
        x_resp_valid = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check(id_ready == 1'b1, "R10", "id_ready", int'(id_ready), 1);
    check(wb_valid == 1'b0, "R10", "wb_valid", int'(wb_valid), 0);
    check(x_req_valid == 1'b0 && x_resp_ready == 1'b0, "R10", "req/resp",
          int'({x_req_valid, x_resp_ready}), 0);
    rst_n = 1'b1;

    // R1: base writes, R9: rd 0
    issue(6'h05, 3'd1, 3'd2, 3'd3, 16'h1111, 16'h2222, 16'hA5A5);
    issue(6'h12, 3'd4, 3'd5, 3'd0, 16'h0001, 16'h0002, 16'hBEEF);
    issue(6'h17, 3'd2, 3'd1, 3'd7, 16'h0003, 16'h0004, 16'h7E57);
    // R2: non-writing base and unspecified opcodes
    issue(6'h1A, 3'd1, 3'd1, 3'd6, 16'h0, 16'h0, 16'hDEAD);
    issue(6'h2C, 3'd3, 3'd3, 3'd2, 16'h0, 16'h0, 16'hCAFE);
    issue(6'h37, 3'd3, 3'd3, 3'd5, 16'h0, 16'h0, 16'hF00D);

    // R3: reserved opcodes with no extension, back-to-back without stall
    ext_present = 1'b0;
    issue(6'h3B, 3'd1, 3'd2, 3'd4, 16'h1234, 16'h5678, 16'h9999);
    issue(6'h38, 3'd1, 3'd2, 3'd5, 16'h1234, 16'h5678, 16'h8888);
    check(last_waits == 0, "R3", "stall cycles", last_waits, 0);
    issue(6'h01, 3'd1, 3'd2, 3'd6, 16'h0, 16'h0, 16'h4321);
    check(last_waits == 0, "R3", "stall cycles", last_waits, 0);

    // R5/R7/R8: claimed opcodes with several ready delays and latencies
    ext_present = 1'b1;
    for (int k = 0; k < 8; k++) begin
      rdy_delay = k % 3;
      resp_lat  = (k * 2) % 5;
      issue(6'(6'h38 + k), 3'(k), 3'(k + 1), 3'(k + 2), 16'(16'h1357 * (k + 1)),
            16'(16'h0F0F + k), 16'h0BAD);
      issue(6'h09, 3'd2, 3'd3, 3'd1, 16'h0, 16'h0, 16'(16'h5000 + k));
      check(last_waits == 2 + rdy_delay + resp_lat, "R7", "stall cycles",
            last_waits, 2 + rdy_delay + resp_lat);
    end
    // R9: extension result aimed at register 0
    rdy_delay = 1; resp_lat = 2;
    issue(6'h3F, 3'd1, 3'd2, 3'd0, 16'hAAAA, 16'h5555, 16'h0);
    issue(6'h2F, 3'd0, 3'd0, 3'd3, 16'h0, 16'h0, 16'h1);
    // R2: mixed stream after extension use
    issue(6'h00, 3'd7, 3'd6, 3'd2, 16'h0, 16'h0, 16'h2468);
    issue(6'h1F, 3'd7, 3'd6, 3'd2, 16'h0, 16'h0, 16'h1357);

    repeat (4) @(negedge clk);
    check(wbq.size() == 0, "R8", "pending writebacks", wbq.size(), 0);
    check(reqq.size() == 0, "R5", "pending requests", reqq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule